// File: doc/BRIEF.md
# Dual-Loop Digital Lock Detector

This block judges whether two phase-locked loops, a main loop and a secondary loop, are in lock. For each loop it receives a one-cycle pulse for every reference-divider edge and every feedback-divider edge. All pulses are synchronous to a fast oscillator clock. The block counts oscillator cycles from the first edge of a pair to the second edge. It then compares that span with a lock window.

A loop is reported as locked only after its span has stayed inside the window for three reference periods in a row. The first measurement outside the window drops that loop's report at once. The two per-loop reports are combined by AND into one lock output. A secondary loop held in standby counts as locked.

The output is not smoothed. When the two loop frequencies differ slightly, the phase drifts in and out of the window and the output toggles. A host reads those transitions as loss of lock.

Top module: `lockdet_dual`

## Requirements
- R1: Synchronous reset clears all measurement and qualification state and drives `lock_o` low; after reset, `lock_o` stays low until a new qualification completes.
- R2: With `main_wide_i` = 0, a main-loop span of up to and including 64 oscillator cycles is in window, and a span of 65 or more is out of window. The span is the number of clock edges from the first edge pulse of a pair to the second.
- R3: A single out-of-window measurement on either loop clears that loop's qualification, and `lock_o` is low no later than two clock cycles after the closing edge.
- R4: A loop reports lock only after three consecutive in-window measurements; `lock_o` rises within two cycles of the closing edge of the third.
- R5: With `main_wide_i` = 1, the main-loop window is 256 cycles: a span of 256 is in window and a span of 257 is out of window.
- R6: The secondary-loop window is 64 cycles whatever the value of `main_wide_i`: a span of 65 is out of window and a span of 64 is in window.
- R7: `lock_o` is high only while both loops report lock; either loop out of window makes it low.
- R8: While `sec_standby_i` is 1, the secondary loop is held cleared and counts as locked, so `lock_o` follows the main loop alone. When standby ends, the secondary loop must qualify again.
- R9: The measurement does not depend on which edge leads: a feedback edge ahead of the reference edge is measured the same way. Pulses on both inputs in the same cycle give a span of zero.
- R10: A pair that never completes counts as out of window. This happens when the leading edge type repeats before its partner arrives, or when the span counter reaches 2^CNT_W-1.
- R11: The qualified output has no filtering beyond R4. A slowly drifting phase that leaves the window from time to time makes `lock_o` rise and fall repeatedly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock that times all measurements |
| rst_i | input | 1 | Synchronous active-high reset |
| main_ref_i | input | 1 | Main-loop reference edge pulse |
| main_fb_i | input | 1 | Main-loop feedback edge pulse |
| sec_ref_i | input | 1 | Secondary-loop reference edge pulse |
| sec_fb_i | input | 1 | Secondary-loop feedback edge pulse |
| main_wide_i | input | 1 | Main-loop window select: 0 for 64 cycles, 1 for 256 cycles |
| sec_standby_i | input | 1 | Secondary loop in standby; counts as locked |
| lock_o | output | 1 | Combined lock indication |

## Verification
A span counter that is off by one shows up only at the window boundaries. For that reason the bench measures spans of 64 against 65, and 256 against 257. A wrong result there appears on `lock_o` within two cycles of the closing edge. A qualification counter that fails to clear or to saturate shows up in the period count: `lock_o` rises after the second period instead of the third, or fails to fall after one bad period. Both are visible in the reference period where the fault occurs. A stuck pair-wait state shows up as a missed drop or a missed relock one reference period after an edge goes missing.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    localparam int unsigned LD_CNT_W      = 10;
    localparam int unsigned LD_QUAL_N     = 3;
    localparam int unsigned LD_WIN_NARROW = 64;
    localparam int unsigned LD_WIN_WIDE   = 256;

    typedef enum logic [1:0] {
        PM_IDLE     = 2'd0,
        PM_WAIT_FB  = 2'd1,
        PM_WAIT_REF = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic valid;
        logic in_win;
    } meas_t;

    function automatic meas_t mk_meas(input logic in_win);
        meas_t m;
        m.valid  = 1'b1;
        m.in_win = in_win;
        return m;
    endfunction

endpackage

// File: rtl/lockdet_phase_meter.sv
module lockdet_phase_meter
    import lockdet_pkg::*;
#(
    parameter int unsigned CNT_W = LD_CNT_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             ref_i,
    input  logic             fb_i,
    input  logic [CNT_W-1:0] win_i,
    output meas_t            meas_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    pm_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             lead_e;
    logic             lag_e;

    always_comb begin
        lead_e = (state_q == PM_WAIT_FB) ? ref_i : fb_i;
        lag_e  = (state_q == PM_WAIT_FB) ? fb_i  : ref_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            state_q <= PM_IDLE;
            cnt_q   <= '0;
            meas_o  <= '0;
        end else begin
            meas_o.valid <= 1'b0;
            case (state_q)
                PM_IDLE: begin
                    if (ref_i && fb_i) begin
                        meas_o <= mk_meas(1'b1);
                    end else if (ref_i) begin
                        state_q <= PM_WAIT_FB;
                        cnt_q   <= CNT_ONE;
                    end else if (fb_i) begin
                        state_q <= PM_WAIT_REF;
                        cnt_q   <= CNT_ONE;
                    end
                end
                PM_WAIT_FB, PM_WAIT_REF: begin
                    if (lag_e) begin
                        meas_o <= mk_meas(cnt_q <= win_i);
                        if (lead_e) begin
                            cnt_q <= CNT_ONE;
                        end else begin
                            state_q <= PM_IDLE;
                            cnt_q   <= '0;
                        end
                    end else if (lead_e) begin
                        meas_o <= mk_meas(1'b0);
                        cnt_q  <= CNT_ONE;
                    end else if (cnt_q == CNT_MAX) begin
                        meas_o  <= mk_meas(1'b0);
                        state_q <= PM_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= PM_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // R10
    wait_cnt_live_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != PM_IDLE) |-> (cnt_q != '0));

    // R9
    coincident_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == PM_IDLE && ref_i && fb_i && !clr_i) |=> (meas_o.valid && meas_o.in_win));

endmodule

// File: rtl/lockdet_qualifier.sv
module lockdet_qualifier
    import lockdet_pkg::*;
#(
    parameter int unsigned QUAL_N = LD_QUAL_N
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  clr_i,
    input  meas_t meas_i,
    output logic  lock_o
);
    localparam int unsigned Q_W = $clog2(QUAL_N + 1);
    localparam logic [Q_W-1:0] Q_FULL = Q_W'(QUAL_N);

    logic [Q_W-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            run_q <= '0;
        end else if (meas_i.valid) begin
            if (!meas_i.in_win) begin
                run_q <= '0;
            end else if (run_q != Q_FULL) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign lock_o = (run_q == Q_FULL);

    // R3
    drop_now_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (meas_i.valid && !meas_i.in_win) |=> !lock_o);

    // R4
    rise_on_good_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(lock_o) |-> $past(meas_i.valid && meas_i.in_win));

endmodule

// File: rtl/lockdet_loop.sv
module lockdet_loop
    import lockdet_pkg::*;
#(
    parameter int unsigned CNT_W  = LD_CNT_W,
    parameter int unsigned QUAL_N = LD_QUAL_N
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             ref_i,
    input  logic             fb_i,
    input  logic [CNT_W-1:0] win_i,
    output logic             lock_o
);
    meas_t meas;

    lockdet_phase_meter #(.CNT_W(CNT_W)) u_meter (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr_i),
        .ref_i  (ref_i),
        .fb_i   (fb_i),
        .win_i  (win_i),
        .meas_o (meas)
    );

    lockdet_qualifier #(.QUAL_N(QUAL_N)) u_qual (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (clr_i),
        .meas_i (meas),
        .lock_o (lock_o)
    );

endmodule

// File: rtl/lockdet_dual.sv
module lockdet_dual
    import lockdet_pkg::*;
#(
    parameter int unsigned CNT_W      = LD_CNT_W,
    parameter int unsigned QUAL_N     = LD_QUAL_N,
    parameter int unsigned WIN_NARROW = LD_WIN_NARROW,
    parameter int unsigned WIN_WIDE   = LD_WIN_WIDE
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic main_ref_i,
    input  logic main_fb_i,
    input  logic sec_ref_i,
    input  logic sec_fb_i,
    input  logic main_wide_i,
    input  logic sec_standby_i,
    output logic lock_o
);
    localparam int unsigned LOOPS = 2;
    localparam logic [CNT_W-1:0] W_NARROW = CNT_W'(WIN_NARROW);
    localparam logic [CNT_W-1:0] W_WIDE   = CNT_W'(WIN_WIDE);

    logic [LOOPS-1:0] ref_v;
    logic [LOOPS-1:0] fb_v;
    logic [LOOPS-1:0] clr_v;
    logic [LOOPS-1:0] loop_lock;
    logic [CNT_W-1:0] win_v [LOOPS];

    always_comb begin
        ref_v    = {sec_ref_i, main_ref_i};
        fb_v     = {sec_fb_i, main_fb_i};
        clr_v    = {sec_standby_i, 1'b0};
        win_v[0] = main_wide_i ? W_WIDE : W_NARROW;
        win_v[1] = W_NARROW;
    end

    for (genvar g = 0; g < LOOPS; g++) begin : g_loop
        lockdet_loop #(.CNT_W(CNT_W), .QUAL_N(QUAL_N)) u_loop (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .clr_i  (clr_v[g]),
            .ref_i  (ref_v[g]),
            .fb_i   (fb_v[g]),
            .win_i  (win_v[g]),
            .lock_o (loop_lock[g])
        );
    end

    assign lock_o = loop_lock[0] & (loop_lock[1] | sec_standby_i);

    // R7
    and_main_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        lock_o |-> loop_lock[0]);

    // R8
    standby_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (sec_standby_i && loop_lock[0]) |-> lock_o);

    // R1
    reset_low_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> !lock_o);

endmodule

// File: tb/lockdet_dual_tb.sv
module lockdet_dual_tb;

    localparam int PER  = 400;
    localparam int MISS = 9999;

    logic clk = 1'b0;
    logic rst, main_ref, main_fb, sec_ref, sec_fb, main_wide, sec_standby;
    logic lock;

    int n_chk = 0;
    int n_err = 0;
    int rises = 0;
    int falls = 0;
    logic prev_lock = 1'b0;

    always #10 clk = ~clk;

    lockdet_dual u_dut (
        .clk_i         (clk),
        .rst_i         (rst),
        .main_ref_i    (main_ref),
        .main_fb_i     (main_fb),
        .sec_ref_i     (sec_ref),
        .sec_fb_i      (sec_fb),
        .main_wide_i   (main_wide),
        .sec_standby_i (sec_standby),
        .lock_o        (lock)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (lock && !prev_lock) rises++;
            if (!lock && prev_lock) falls++;
        end
        prev_lock = lock;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: lock_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // one reference period; offset >0: fb lags ref, <0: fb leads, MISS: no fb
    task automatic period(input int m_off, input int s_off, input bit sec_on);
        int mr, mf, sr, sf;
        mr = (m_off < 0) ? -m_off : 0;
        mf = (m_off == MISS) ? -1 : ((m_off < 0) ? 0 : m_off);
        sr = (s_off < 0) ? -s_off : 0;
        sf = (s_off == MISS) ? -1 : ((s_off < 0) ? 0 : s_off);
        if (!sec_on) begin
            sr = -1;
            sf = -1;
        end
        for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            main_ref = (c == mr);
            main_fb  = (c == mf);
            sec_ref  = (c == sr);
            sec_fb   = (c == sf);
        end
        @(negedge clk);
    endtask

    task automatic periods(input int n, input int m_off, input int s_off, input bit sec_on);
        for (int i = 0; i < n; i++) period(m_off, s_off, sec_on);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset", lock, 1'b0);
    endtask

    task automatic t_qualify();
        periods(2, 10, 10, 1'b1);
        chk("R4 two periods", lock, 1'b0);
        period(10, 10, 1'b1);
        chk("R4 third period", lock, 1'b1);
    endtask

    task automatic t_main_narrow();
        period(64, 10, 1'b1);
        chk("R2 span 64", lock, 1'b1);
        period(65, 10, 1'b1);
        chk("R2 R3 span 65", lock, 1'b0);
        periods(2, 10, 10, 1'b1);
        chk("R3 requalify", lock, 1'b0);
        period(10, 10, 1'b1);
        chk("R4 relock", lock, 1'b1);
    endtask

    task automatic t_main_wide();
        main_wide = 1'b1;
        periods(3, 256, 10, 1'b1);
        chk("R5 span 256", lock, 1'b1);
        period(257, 10, 1'b1);
        chk("R5 span 257", lock, 1'b0);
    endtask

    task automatic t_sec_fixed();
        periods(3, 100, 64, 1'b1);
        chk("R6 sec span 64", lock, 1'b1);
        period(100, 65, 1'b1);
        chk("R6 R7 sec span 65", lock, 1'b0);
        main_wide = 1'b0;
        periods(3, 10, 10, 1'b1);
        period(70, 10, 1'b1);
        chk("R7 main out", lock, 1'b0);
    endtask

    task automatic t_order();
        periods(3, -30, -20, 1'b1);
        chk("R9 fb leads", lock, 1'b1);
        period(-65, -20, 1'b1);
        chk("R9 fb leads by 65", lock, 1'b0);
        do_reset();
        periods(3, 0, 0, 1'b1);
        chk("R9 coincident", lock, 1'b1);
    endtask

    task automatic t_missing();
        period(MISS, 10, 1'b1);
        period(10, 10, 1'b1);
        chk("R10 missing fb", lock, 1'b0);
        periods(3, 10, 10, 1'b1);
        chk("R10 recovery", lock, 1'b1);
    endtask

    task automatic t_standby();
        do_reset();
        sec_standby = 1'b1;
        periods(3, 10, 0, 1'b0);
        chk("R8 standby locked", lock, 1'b1);
        period(80, 0, 1'b0);
        chk("R8 main rules", lock, 1'b0);
        periods(3, 10, 0, 1'b0);
        sec_standby = 1'b0;
        period(10, 0, 1'b0);
        chk("R8 leave standby", lock, 1'b0);
    endtask

    task automatic t_chatter();
        sec_standby = 1'b1;
        period(70, 0, 1'b0);
        rises = 0;
        falls = 0;
        for (int k = 0; k < 3; k++) begin
            periods(4, 20, 0, 1'b0);
            period(80, 0, 1'b0);
        end
        n_chk++;
        if (rises < 2 || falls < 2) begin
            n_err++;
            $display("FAIL R11 chatter: rises=%0d falls=%0d expected >=2 each", rises, falls);
        end
    endtask

    task automatic t_reset_mid();
        periods(3, 20, 0, 1'b0);
        chk("R4 before reset", lock, 1'b1);
        do_reset();
        chk("R1 reset while locked", lock, 1'b0);
    endtask

    initial begin
        rst = 1'b1;
        main_ref = 1'b0; main_fb = 1'b0; sec_ref = 1'b0; sec_fb = 1'b0;
        main_wide = 1'b0; sec_standby = 1'b0;
        t_reset();
        t_qualify();
        t_main_narrow();
        t_main_wide();
        t_sec_fixed();
        t_order();
        t_missing();
        t_standby();
        t_chatter();
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule